// File: doc/BRIEF.md
# SMBus Register Target with Packet Error Code and Bus Timeout

This block is the serial front end of a register-based peripheral. It watches an oversampled two-wire bus (clock and data), finds start and stop conditions, and answers at a 7-bit address. The three low address bits are set by a three-level strap input. The block pulls the data line low through an open-drain enable, and only while the bus clock is low. The block then turns bus traffic into byte-wide accesses on a simple register port. The first byte of a write selects a register pointer. The bytes that follow are written at that pointer, and reads return bytes from that pointer. The pointer steps by one after each data byte.

Each transaction can end with an optional CRC-8 packet error code. On a read, the block sends the code when the controller clocks one more byte. On a write, the block checks the code it receives. The block also holds one configuration register. Bit 6 of that register turns on an inactivity watchdog, which drops a stalled transfer and releases the data line.

Top module: `smb_target`

## Requirements
- R1: The target address is 1001 followed by three bits taken from `addr_sel`: code 00 gives 000, code 01 gives 010, code 10 gives 011, and code 11 behaves like 10. A matching address byte is acknowledged.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. `sda_oe` changes only while SCL is low, except when the timeout releases it.
- R3: The address byte arrives MSB first, with bit 0 as direction (0 = write, 1 = read). The acknowledge is a low SDA held through the ninth SCL pulse.
- R4: When the address does not match, the block drives nothing until the next start.
- R5: In a write, the first data byte loads the register pointer. The next WR_BYTES bytes are each written at the pointer with a one-cycle `reg_we`, and the pointer steps by one after each. Every one of these bytes is acknowledged.
- R6: In a read, each byte is taken from `reg_rdata` at `reg_addr` = pointer and sent MSB first. `reg_rd` pulses for one cycle, and the pointer steps by one after the byte.
- R7: A controller NACK on a read byte ends the read. SDA stays released (reads as 0xFF) until the next start or stop.
- R8: A repeated start without a stop is accepted. It decodes the address again and keeps the register pointer.
- R9: The packet error code is CRC-8 with polynomial 0x07, cleared to 0x00 at a start outside a frame and kept across repeated starts. It covers every address byte and every data byte. In a read, the byte after RD_BYTES data bytes is the CRC. In a write, the byte after WR_BYTES data bytes is compared with the CRC and acknowledged if it is equal.
- R10: A write code byte that does not match is NACKed, and `pec_error` pulses for exactly one cycle.
- R11: In a write, a byte after the code position is NACKed and not stored. In a read, a byte after the code position is sent as 0xFF.
- R12: A write to register CFG_REG (default 0x18) copies data bit 6 into the timeout enable, which is 0 after reset. When it is enabled, TIMEOUT_CYC clock cycles inside a frame with no SCL or SDA edge release SDA and return the block to idle. When it is disabled, a stall is held indefinitely.
- R13: After reset, and after a stop, SDA is released and clocked bits are ignored until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 2 | Three-level strap code: 00 low, 01 floating, 10 high |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle strobe marking a read byte taken |
| reg_rdata | input | 8 | Read data for `reg_addr`, valid in the same cycle |
| pec_error | output | 1 | One-cycle pulse on a bad write code |

## Verification
The hardest case to reach is the timeout. It needs an enable bit that can only be set by a bus write, and it needs a stall that leaves the block itself holding SDA low. The bench first writes 0x00 into a register and reads it back with the clock held low right after the address acknowledge. The block is then driving the first data bit low, and the bench waits well past TIMEOUT_CYC. It does this once with the enable clear and once after writing bit 6 of the configuration register. Codes that do not match, bytes past the code position, and repeated starts to a foreign address are each driven as directed cases. Random write and read-back pairs follow, with random straps, pointers, data and code use.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } smb_state_t;

  // one byte through the 0x07 polynomial, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic [6:0] strap_addr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'b1001000;
      2'b01:   return 7'b1001010;
      default: return 7'b1001011;
    endcase
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign dout = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/smb_crc8.sv
module smb_crc8 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import smb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= 8'h00;
    else if (upd)   crc <= crc8_step(crc, din);
  end
endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
  parameter int CYC = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic busy,
  input  logic activity,
  output logic expire
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || !busy || activity) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (cnt == CW'(CYC - 1)) begin
      cnt    <= '0;
      expire <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_target.sv
module smb_target #(
  parameter int         TIMEOUT_CYC = 2500000,
  parameter int         SYNC_STAGES = 2,
  parameter int         WR_BYTES    = 1,
  parameter int         RD_BYTES    = 1,
  parameter logic [7:0] CFG_REG     = 8'h18,
  parameter int         TO_EN_BIT   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_sel,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata,
  output logic       pec_error
);
  import smb_pkg::*;

  localparam int PEC_WR_IDX = WR_BYTES + 1;
  localparam int PEC_RD_IDX = RD_BYTES;
  localparam int IDX_MAX    = (WR_BYTES + 2 > RD_BYTES + 1) ? WR_BYTES + 2 : RD_BYTES + 1;
  localparam int IDXW       = $clog2(IDX_MAX + 1);

  logic scl_s, scl_r, scl_f, sda_s, sda_r, sda_f;
  logic start_det, stop_det, to_expire;

  smb_state_t      state;
  logic [3:0]      bitcnt;
  logic [7:0]      sr, txsr, ptr;
  logic [IDXW-1:0] byte_idx, idx_inc;
  logic            is_addr, rw, in_frame, ptr_inc, cont, cfg_to_en;
  logic            crc_clr, crc_upd;
  logic [7:0]      crc_din, crc_val, tx_next;
  logic [6:0]      my_addr;
  logic            addr_hit, pec_ok, load_now;

  smb_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s), .rise(scl_r), .fall(scl_f));
  smb_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s), .rise(sda_r), .fall(sda_f));

  smb_crc8 u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .upd(crc_upd), .din(crc_din), .crc(crc_val));

  smb_timeout #(.CYC(TIMEOUT_CYC)) u_to (
    .clk(clk), .rst(rst), .en(cfg_to_en), .busy(in_frame),
    .activity(scl_r | scl_f | sda_r | sda_f), .expire(to_expire));

  assign start_det = sda_f & scl_s;
  assign stop_det  = sda_r & scl_s;
  assign reg_addr  = ptr;

  always_comb begin
    my_addr  = strap_addr(addr_sel);
    addr_hit = (sr[7:1] == my_addr);
    pec_ok   = (sr == crc_val);
    idx_inc  = (int'(byte_idx) == IDX_MAX) ? byte_idx : byte_idx + IDXW'(1);
    if (int'(byte_idx) < PEC_RD_IDX)       tx_next = reg_rdata;
    else if (int'(byte_idx) == PEC_RD_IDX) tx_next = crc_val;
    else                                   tx_next = 8'hFF;
    load_now = scl_f && ((state == ST_ACK && rw) || (state == ST_RACK && cont));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      sr        <= '0;
      txsr      <= '0;
      ptr       <= '0;
      byte_idx  <= '0;
      is_addr   <= 1'b0;
      rw        <= 1'b0;
      in_frame  <= 1'b0;
      ptr_inc   <= 1'b0;
      cont      <= 1'b0;
      cfg_to_en <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
      pec_error <= 1'b0;
      crc_clr   <= 1'b0;
      crc_upd   <= 1'b0;
      crc_din   <= '0;
    end else begin
      reg_we    <= 1'b0;
      reg_rd    <= 1'b0;
      pec_error <= 1'b0;
      crc_clr   <= 1'b0;
      crc_upd   <= 1'b0;
      if (to_expire || stop_det) begin
        state    <= ST_IDLE;
        in_frame <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (start_det) begin
        if (!in_frame) crc_clr <= 1'b1;
        in_frame <= 1'b1;
        state    <= ST_RX;
        is_addr  <= 1'b1;
        bitcnt   <= '0;
        ptr_inc  <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_r) begin
              sr     <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_f && bitcnt == 4'd8) begin
              if (is_addr) begin
                if (addr_hit) begin
                  rw       <= sr[0];
                  byte_idx <= '0;
                  sda_oe   <= 1'b1;
                  crc_upd  <= 1'b1;
                  crc_din  <= sr;
                  state    <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (int'(byte_idx) == 0) begin
                ptr      <= sr;
                sda_oe   <= 1'b1;
                crc_upd  <= 1'b1;
                crc_din  <= sr;
                byte_idx <= idx_inc;
                state    <= ST_ACK;
              end else if (int'(byte_idx) <= WR_BYTES) begin
                reg_we    <= 1'b1;
                reg_wdata <= sr;
                ptr_inc   <= 1'b1;
                if (ptr == CFG_REG) cfg_to_en <= sr[TO_EN_BIT];
                sda_oe    <= 1'b1;
                crc_upd   <= 1'b1;
                crc_din   <= sr;
                byte_idx  <= idx_inc;
                state     <= ST_ACK;
              end else if (int'(byte_idx) == PEC_WR_IDX) begin
                byte_idx <= idx_inc;
                if (pec_ok) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end else begin
                  pec_error <= 1'b1;
                  state     <= ST_IDLE;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_f) begin
              if (ptr_inc) begin
                ptr     <= ptr + 8'd1;
                ptr_inc <= 1'b0;
              end
              bitcnt  <= '0;
              is_addr <= 1'b0;
              if (!rw) begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_r) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_f) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~txsr[6];
                txsr   <= {txsr[6:0], 1'b1};
              end
            end
          end
          ST_RACK: begin
            if (scl_r) begin
              cont <= ~sda_s;
              if (ptr_inc) begin
                ptr     <= ptr + 8'd1;
                ptr_inc <= 1'b0;
              end
            end else if (scl_f && !cont) begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
        if (load_now) begin
          txsr     <= tx_next;
          sda_oe   <= ~tx_next[7];
          bitcnt   <= '0;
          byte_idx <= idx_inc;
          state    <= ST_TX;
          if (int'(byte_idx) < PEC_RD_IDX) begin
            reg_rd  <= 1'b1;
            ptr_inc <= 1'b1;
            crc_upd <= 1'b1;
            crc_din <= tx_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_rd,
  input logic pec_error,
  input logic to_expire,
  input logic cfg_to_en
);
  assert_sda_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(to_expire)) |-> !scl_i);

  assert_write_acked_R5: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> sda_oe);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_rd));

  assert_pec_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    pec_error |=> !pec_error);

  assert_pec_nack_R10: assert property (@(posedge clk) disable iff (rst)
    pec_error |-> !sda_oe);

  assert_timeout_release_R12: assert property (@(posedge clk) disable iff (rst)
    to_expire |=> !sda_oe);

  assert_timeout_gated_R12: assert property (@(posedge clk) disable iff (rst)
    to_expire |-> $past(cfg_to_en));

  assert_timeout_reset_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cfg_to_en);
endmodule

bind smb_target smb_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_rd(reg_rd), .pec_error(pec_error), .to_expire(to_expire), .cfg_to_en(cfg_to_en));

// File: tb/tb_smb_target.sv
`timescale 1ns/1ps
module tb_smb_target;
  localparam int TO  = 300;
  localparam int H   = 10;
  localparam logic [7:0] CFG = 8'h18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_c = 1'b1, sda_c = 1'b1;
  logic sda_oe, reg_we, reg_rd, pec_error;
  logic [1:0] addr_sel = 2'b00;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] regs [256];
  int checks = 0, fails = 0, pec_cnt = 0, rd_cnt = 0;

  always #5 clk = ~clk;
  assign sda_bus   = sda_c & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  smb_target #(.TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_c), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pec_error(pec_error));

  always @(posedge clk) begin
    if (reg_we) regs[reg_addr] <= reg_wdata;
    if (reg_rd) rd_cnt <= rd_cnt + 1;
    if (pec_error) pec_cnt <= pec_cnt + 1;
  end

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [6:0] taddr(input logic [1:0] s);
    return (s == 2'b00) ? 7'h48 : (s == 2'b01) ? 7'h4A : 7'h4B;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start();
    sda_c = 1'b1; wt(H); scl_c = 1'b1; wt(H); sda_c = 1'b0; wt(H); scl_c = 1'b0;
  endtask

  task automatic stop();
    wt(2); sda_c = 1'b0; wt(H); scl_c = 1'b1; wt(H); sda_c = 1'b1; wt(H);
  endtask

  task automatic put_bit(input logic b);
    wt(2); sda_c = b; wt(H - 2); scl_c = 1'b1; wt(H); scl_c = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wt(2); sda_c = 1'b1; wt(H - 2); scl_c = 1'b1; wt(H / 2); b = sda_bus; wt(H - H / 2); scl_c = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                        input bit use_pec, input logic [7:0] flip,
                        output bit acks, output logic kp);
    logic k0, k1, k2;
    logic [7:0] c;
    c = crc8(crc8(crc8(8'h00, {a, 1'b0}), p), d);
    start();
    wbyte({a, 1'b0}, k0); wbyte(p, k1); wbyte(d, k2);
    kp = 1'b0;
    if (use_pec) wbyte(c ^ flip, kp);
    stop();
    acks = k0 & k1 & k2;
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic [7:0] p, input bit use_pec,
                        output logic [7:0] d, output logic [7:0] pc, output bit acks);
    logic k0, k1, k2;
    start();
    wbyte({a, 1'b0}, k0); wbyte(p, k1);
    start();
    wbyte({a, 1'b1}, k2);
    rbyte(d, use_pec);
    pc = 8'h00;
    if (use_pec) rbyte(pc, 1'b0);
    stop();
    acks = k0 & k1 & k2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic k, kp;
    bit ok;
    logic [7:0] d, pc, e;
    int seed, p0, r0;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 256; i++) regs[i] = 8'h00;
    wt(6); rst = 1'b0; wt(2);
    // reset state, R13
    chk(sda_oe == 1'b0 && reg_we == 1'b0 && pec_error == 1'b0, "R13 reset", {sda_oe, reg_we, pec_error}, 0);

    // strap decoding, R1 R3 R4
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      start(); wbyte({taddr(2'(s)), 1'b0}, k); stop();
      chk(k == 1'b1, "R1 strap ack", k, 1);
      start(); wbyte({taddr(2'(s)) ^ 7'h01, 1'b0}, k);
      chk(k == 1'b0, "R4 foreign address nack", k, 0);
      wbyte(8'h00, k);
      chk(k == 1'b0 && sda_oe == 1'b0, "R4 idle after mismatch", k, 0);
      stop();
    end
    addr_sel = 2'b00;

    // bits without start after stop, R13
    wbyte(8'h90, k);
    chk(k == 1'b0, "R13 ignored without start", k, 0);

    // plain write and read, R5 R6 R8
    wr_txn(7'h48, 8'h20, 8'hA5, 0, 8'h00, ok, kp);
    chk(ok, "R5 write acks", ok, 1);
    chk(regs[8'h20] == 8'hA5, "R5 stored", regs[8'h20], 8'hA5);
    r0 = rd_cnt;
    rd_txn(7'h48, 8'h20, 0, d, pc, ok);
    chk(ok && d == 8'hA5, "R6 R8 read back", d, 8'hA5);
    chk(rd_cnt == r0 + 1, "R6 read strobe", rd_cnt, r0 + 1);

    // repeated start to foreign address, R8
    start(); wbyte(8'h90, k); wbyte(8'h20, k); start(); wbyte(8'h97, k);
    chk(k == 1'b0, "R8 redecode on repeated start", k, 0);
    stop();

    // NACK ends read, R7
    start(); wbyte(8'h90, k); wbyte(8'h20, k); start(); wbyte(8'h91, k);
    rbyte(d, 1'b0); rbyte(e, 1'b0); stop();
    chk(e == 8'hFF, "R7 released after nack", e, 8'hFF);

    // good and bad write code, R9 R10
    p0 = pec_cnt;
    wr_txn(7'h48, 8'h40, 8'h5C, 1, 8'h00, ok, kp);
    chk(ok && kp == 1'b1 && pec_cnt == p0, "R9 good code acked", {kp, 8'(pec_cnt - p0)}, 9'h100);
    wr_txn(7'h48, 8'h41, 8'h33, 1, 8'h01, ok, kp);
    wt(2);
    chk(kp == 1'b0, "R10 bad code nack", kp, 0);
    chk(pec_cnt == p0 + 1, "R10 error pulse", pec_cnt, p0 + 1);

    // read code over both address bytes, R9; read past code, R11
    start(); wbyte(8'h90, k); wbyte(8'h40, k); start(); wbyte(8'h91, k);
    rbyte(d, 1'b1); rbyte(pc, 1'b1); rbyte(e, 1'b0); stop();
    chk(pc == crc8(crc8(crc8(crc8(8'h00, 8'h90), 8'h40), 8'h91), 8'h5C), "R9 read code", pc,
        crc8(crc8(crc8(crc8(8'h00, 8'h90), 8'h40), 8'h91), 8'h5C));
    chk(e == 8'hFF, "R11 read past code", e, 8'hFF);

    // write past code, R11
    wr_txn(7'h48, 8'h51, 8'h3C, 0, 8'h00, ok, kp);
    start(); wbyte(8'h90, k); wbyte(8'h50, k); wbyte(8'h11, k);
    wbyte(crc8(crc8(crc8(8'h00, 8'h90), 8'h50), 8'h11), k);
    wbyte(8'h99, k); stop();
    chk(k == 1'b0, "R11 extra write nack", k, 0);
    chk(regs[8'h51] == 8'h3C, "R11 extra not stored", regs[8'h51], 8'h3C);

    // timeout disabled, R12
    wr_txn(7'h48, 8'h30, 8'h00, 0, 8'h00, ok, kp);
    start(); wbyte(8'h90, k); wbyte(8'h30, k); start(); wbyte(8'h91, k);
    wt(20);
    chk(sda_oe == 1'b1, "R12 stall held", sda_oe, 1);
    wt(2 * TO);
    chk(sda_oe == 1'b1, "R12 disabled keeps hold", sda_oe, 1);
    rbyte(d, 1'b0); stop();

    // timeout enabled, R12
    wr_txn(7'h48, CFG, 8'h40, 0, 8'h00, ok, kp);
    start(); wbyte(8'h90, k); wbyte(8'h30, k); start(); wbyte(8'h91, k);
    wt(20);
    chk(sda_oe == 1'b1, "R12 stall before expiry", sda_oe, 1);
    wt(2 * TO);
    chk(sda_oe == 1'b0, "R12 released on expiry", sda_oe, 0);
    stop();
    wr_txn(7'h48, CFG, 8'h00, 0, 8'h00, ok, kp);

    // random write and read-back pairs, R1 R5 R6 R9
    for (int it = 0; it < 30; it++) begin
      logic [1:0] s;
      logic [7:0] p, v;
      bit up;
      s  = 2'($urandom_range(0, 3));
      p  = {2'b01, 6'($urandom)};
      v  = 8'($urandom);
      up = 1'($urandom);
      addr_sel = s;
      wr_txn(taddr(s), p, v, up, 8'h00, ok, kp);
      chk(ok && (!up || kp), "R5 random write acks", {ok, kp}, 2'b11);
      rd_txn(taddr(s), p, 1, d, pc, ok);
      chk(ok && d == v, "R6 random read", d, v);
      e = crc8(crc8(crc8(crc8(8'h00, {taddr(s), 1'b0}), p), {taddr(s), 1'b1}), v);
      chk(pc == e, "R9 random read code", pc, e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule